// File: doc/BRIEF.md
# Framed byte receiver with abort recovery

This block sits behind a serial line decoder that hands over one byte per valid strobe. While idle it hunts for a start marker byte. Once the marker is seen it writes every following data byte into a dual-port record memory, at the address held by a write pointer. A closing end marker commits the record: a one-cycle ready pulse carries the record's start address and length to the reader side. The reader fetches the bytes through the memory's second port.

A frame that never closes must not hold the receiver. Noise on the line can look like a start marker, and a frame can be truncated. The capture loop is therefore bounded in two ways: by a silence timeout and by a maximum frame length. On either bound the partial record is dropped and the write pointer returns to the record's first slot. A one-cycle error pulse is raised that can serve as a trigger, a saturating counter of aborts is updated, and hunting resumes with no outside reset.

The write pointer and the register that holds the current record's start address sit in one process under one reset. Neither can leave reset while the other is still held.

Top module: `frame_rx`

## Requirements
- R1: While reset is held and after it, `rec_rdy` and `err_pulse` are 0, `err_cnt` is 0, and the first committed record starts at address 0.
- R2: While hunting, every byte other than the start marker (0xA5), including the end marker (0x5A), is ignored: it raises no pulse and does not move where the next record starts.
- R3: Data bytes between the start and end markers are stored at consecutive addresses from the record's start address. Marker bytes are not stored. A byte written there is returned on `rd_data` one clock after `rd_addr` presents its address.
- R4: An end marker during capture makes `rec_rdy` high for exactly one cycle, starting with the clock edge that accepts the end marker. In that cycle `rec_addr` is the record's start address and `rec_len` is its data byte count.
- R5: Each committed record starts where the previous committed record ended, that is at start plus length, modulo 2^ADDR_W.
- R6: During capture, IDLE_TO (64) consecutive clock cycles without a valid byte abort the frame. A byte that arrives after 63 idle cycles keeps the frame alive.
- R7: A data byte that would take the count beyond MAX_LEN (256) aborts the frame. A frame of exactly MAX_LEN data bytes followed by the end marker commits with length 256.
- R8: An abort raises `err_pulse` for exactly one cycle, starting with the edge that detects it, and raises no `rec_rdy`. The write pointer is restored, so the next committed record starts at the aborted record's start address.
- R9: After an abort the receiver hunts again with no reset. Bytes before the next start marker are ignored, and the next frame is captured and stored normally.
- R10: A start marker during capture discards the bytes taken so far and restarts the record at the same start address, with no error pulse.
- R11: `err_cnt` increments by one on each abort and saturates at 2^ERRCNT_W-1 (15).
- R12: A start marker followed directly by an end marker commits a record of length 0, and the next record starts at the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Byte strobe from the line decoder |
| in_byte | input | DATA_W (8) | Received byte, valid when `in_vld` is high |
| rd_addr | input | ADDR_W (10) | Reader-side memory address |
| rd_data | output | DATA_W (8) | Reader-side data, one cycle after `rd_addr` |
| rec_rdy | output | 1 | One-cycle pulse: a record is complete |
| rec_addr | output | ADDR_W (10) | Start address of the record just completed |
| rec_len | output | $clog2(MAX_LEN+1) (9) | Data byte count of the record just completed |
| err_pulse | output | 1 | One-cycle pulse on an aborted frame |
| err_cnt | output | ERRCNT_W (4) | Saturating count of aborted frames |

## Verification
Bytes are driven just after a falling edge. Every result is registered at the rising edge that takes the byte, so `rec_rdy`, `rec_len`, `rec_addr` and `err_pulse` are sampled at the falling edge that follows: half a cycle after the deciding byte or idle cycle. The checks then wait one more cycle to confirm the pulse is gone. Read data is due one rising edge after `rd_addr` changes and is sampled at the next falling edge. For the timeout, the bench counts idle cycles from the edge of the last accepted byte. It confirms there is no error after 63 idle cycles and an error after the 64th.

// File: rtl/frame_rx_pkg.sv
// Package: shared types of the framed byte receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package frame_rx_pkg;
    // Receiver control state: hunting for a start marker, or capturing a frame.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_CAPT = 1'b1
    } rx_state_t;
endpackage

// File: rtl/frame_rx_ptr.sv
// Module: record write pointer with its start-address register.
// Writes advance the pointer, a commit makes the pointer the next start,
// and a restore puts the pointer back on the current start.
// Assumes: restore and commit are never high together. Both registers share
// one reset inside one process, so neither leaves reset alone.
module frame_rx_ptr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              restore,
    input  logic              commit,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] start
);

    // Pointer and start register, cleared together by the same reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            start <= '0;
        end else begin
            if (restore)
                wptr <= start;
            else if (advance)
                wptr <= wptr + 1'b1;
            if (commit)
                start <= wptr;
        end
    end

    // R8: a restore puts the pointer back on the record start.
    a_r8_restore_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (wptr == $past(start)));

    // R5: a commit makes the next record begin where this one ended.
    a_r5_commit_start: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (start == $past(wptr)));

    // R8: the controller never restores and commits in the same cycle.
    a_r8_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(restore && commit));

endmodule

// File: rtl/frame_rx_ram.sv
// Module: simple dual-port record memory, one write port and one read port.
// Reads are registered and return data one clock after the address.
// Assumes: the reader only reads addresses of committed records.
module frame_rx_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read port: registered data, one cycle of latency.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/frame_rx_ctl.sv
// Module: hunt/capture controller with a bounded byte loop.
// It decides for each cycle whether to store, commit, restart or abort.
// An abort is caused by IDLE_TO silent cycles or by a byte beyond MAX_LEN.
// Assumes: SOF_BYTE differs from EOF_BYTE, and IDLE_TO >= 2.
module frame_rx_ctl
    import frame_rx_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                MAX_LEN  = 256,
    parameter int                IDLE_TO  = 64,
    parameter int                ERRCNT_W = 4,
    parameter logic [DATA_W-1:0] SOF_BYTE = 8'hA5,
    parameter logic [DATA_W-1:0] EOF_BYTE = 8'h5A,
    localparam int               LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [DATA_W-1:0]   in_byte,
    output logic                store,
    output logic                restore,
    output logic                commit,
    output logic                rec_rdy,
    output logic [LEN_W-1:0]    rec_len,
    output logic                err_pulse,
    output logic [ERRCNT_W-1:0] err_cnt
);

    localparam int             IDLE_W    = $clog2(IDLE_TO);
    localparam logic [LEN_W-1:0]  LEN_MAX   = LEN_W'(MAX_LEN);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TO - 1);

    rx_state_t         state;
    logic [LEN_W-1:0]  len;
    logic [IDLE_W-1:0] idle;
    logic              is_sof, is_eof, is_dat, start, abort;

    // Per-cycle decisions from the state and the incoming byte.
    always_comb begin
        is_sof  = in_vld && (in_byte == SOF_BYTE);
        is_eof  = in_vld && (in_byte == EOF_BYTE);
        is_dat  = in_vld && !is_sof && !is_eof;
        start   = is_sof;
        store   = 1'b0;
        commit  = 1'b0;
        abort   = 1'b0;
        restore = 1'b0;
        if (state == ST_CAPT) begin
            commit  = is_eof;
            abort   = (is_dat && (len == LEN_MAX)) || (!in_vld && (idle == IDLE_LAST));
            store   = is_dat && (len != LEN_MAX);
            restore = abort || is_sof;
        end
    end

    // State, byte count and idle counter of the capture loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            len   <= '0;
            idle  <= '0;
        end else if (start) begin
            state <= ST_CAPT;
            len   <= '0;
            idle  <= '0;
        end else if (commit || abort) begin
            state <= ST_HUNT;
            len   <= '0;
            idle  <= '0;
        end else if (state == ST_CAPT) begin
            if (store)
                len <= len + 1'b1;
            idle <= in_vld ? '0 : idle + 1'b1;
        end
    end

    // Result outputs: ready and error pulses, record length, abort counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_rdy   <= 1'b0;
            rec_len   <= '0;
            err_pulse <= 1'b0;
            err_cnt   <= '0;
        end else begin
            rec_rdy   <= commit;
            err_pulse <= abort;
            if (commit)
                rec_len <= len;
            if (abort && (err_cnt != '1))
                err_cnt <= err_cnt + 1'b1;
        end
    end

    // R4: the ready flag lasts a single cycle.
    a_r4_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rdy |=> !rec_rdy);

    // R8: the error flag lasts a single cycle.
    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R8: an aborted frame is never announced as ready.
    a_r8_no_rdy_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_rdy && err_pulse));

    // R11: the abort counter never goes down.
    a_r11_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt >= $past(err_cnt));

    // R7: a committed length never exceeds the frame limit.
    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rdy |-> (rec_len <= LEN_MAX));

endmodule

// File: rtl/frame_rx.sv
// Module: top of the framed byte receiver.
// It joins the controller, the write pointer and the record memory, and it
// latches the start address of each committed record for the reader side.
// Assumes: in_byte is stable whenever in_vld is high.
module frame_rx #(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 10,
    parameter int                MAX_LEN  = 256,
    parameter int                IDLE_TO  = 64,
    parameter int                ERRCNT_W = 4,
    parameter logic [DATA_W-1:0] SOF_BYTE = 8'hA5,
    parameter logic [DATA_W-1:0] EOF_BYTE = 8'h5A
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_vld,
    input  logic [DATA_W-1:0]              in_byte,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           rec_rdy,
    output logic [ADDR_W-1:0]              rec_addr,
    output logic [$clog2(MAX_LEN+1)-1:0]   rec_len,
    output logic                           err_pulse,
    output logic [ERRCNT_W-1:0]            err_cnt
);

    logic              store, restore, commit;
    logic [ADDR_W-1:0] wptr, start;

    frame_rx_ctl #(
        .DATA_W   (DATA_W),
        .MAX_LEN  (MAX_LEN),
        .IDLE_TO  (IDLE_TO),
        .ERRCNT_W (ERRCNT_W),
        .SOF_BYTE (SOF_BYTE),
        .EOF_BYTE (EOF_BYTE)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_byte   (in_byte),
        .store     (store),
        .restore   (restore),
        .commit    (commit),
        .rec_rdy   (rec_rdy),
        .rec_len   (rec_len),
        .err_pulse (err_pulse),
        .err_cnt   (err_cnt)
    );

    frame_rx_ptr #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (store),
        .restore (restore),
        .commit  (commit),
        .wptr    (wptr),
        .start   (start)
    );

    frame_rx_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (store),
        .waddr (wptr),
        .wdata (in_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Record start address presented with the ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec_addr <= '0;
        else if (commit)
            rec_addr <= start;
    end

    // R3: no byte is written while a restore discards the record.
    a_r3_no_store_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && restore));

    // R4: the announced address holds steady between ready pulses.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_rdy |-> $stable(rec_addr));

endmodule

// File: tb/test_frame_rx.sv
module test_frame_rx;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam logic [7:0] SOF = 8'hA5;
    localparam logic [7:0] EOF = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_vld;
    logic [7:0]        in_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              rec_rdy;
    logic [ADDR_W-1:0] rec_addr;
    logic [8:0]        rec_len;
    logic              err_pulse;
    logic [3:0]        err_cnt;

    frame_rx i_frame_rx (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .rd_addr(rd_addr), .rd_data(rd_data), .rec_rdy(rec_rdy),
        .rec_addr(rec_addr), .rec_len(rec_len), .err_pulse(err_pulse),
        .err_cnt(err_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [ADDR_W-1:0] exp_start = '0;
    int exp_errs = 0;

    // Frame table: {idle gap before frame, data length, data seed}.
    localparam logic [24:0] VEC [6] = '{
        {8'd0, 9'd3,  8'h10},
        {8'd5, 9'd1,  8'h20},
        {8'd2, 9'd0,  8'h30},   // R12 empty frame
        {8'd2, 9'd17, 8'h40},
        {8'd1, 9'd62, 8'h80},
        {8'd0, 9'd5,  8'hF0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
        logic [7:0] b;
        b = seed + 8'(i);
        if (b == SOF || b == EOF)
            b = b ^ 8'h01;
        return b;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        in_vld  = 1'b1;
        in_byte = b;
        tick();
        in_vld  = 1'b0;
        in_byte = 8'h00;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        send(SOF);
        for (int i = 0; i < len; i++)
            send(dat(seed, i));
        send(EOF);
    endtask

    // Check the ready pulse, its address and length, then its end.
    task automatic expect_commit(input string req, input int len);
        chk({req, " rec_rdy"}, int'(rec_rdy), 1);
        chk({req, " rec_addr"}, int'(rec_addr), int'(exp_start));
        chk({req, " rec_len"}, int'(rec_len), len);
        chk({req, " err_pulse"}, int'(err_pulse), 0);
        tick();
        chk({req, " rec_rdy single cycle"}, int'(rec_rdy), 0);
    endtask

    // Read a record back through the reader port; one check per record.
    task automatic readback(input string req, input int len, input logic [7:0] seed);
        int bad;
        int first_act;
        int first_exp;
        bad = 0;
        first_act = 0;
        first_exp = 0;
        for (int i = 0; i < len; i++) begin
            rd_addr = exp_start + ADDR_W'(i);
            tick();
            if (rd_data != dat(seed, i)) begin
                if (bad == 0) begin
                    first_act = int'(rd_data);
                    first_exp = int'(dat(seed, i));
                end
                bad++;
            end
        end
        chk({req, " stored bytes"}, first_act, first_exp);
    endtask

    task automatic good_frame(input string req, input int len, input logic [7:0] seed);
        send_frame(len, seed);
        expect_commit(req, len);
        readback(req, len, seed);
        exp_start = exp_start + ADDR_W'(len);
    endtask

    // Start a frame that dies of silence after IDLE_TO cycles.
    task automatic idle_abort();
        send(SOF);
        repeat (63) tick();
        chk("R6 no abort before timeout", int'(err_pulse), 0);
        tick();
        chk("R6 abort on 64th idle cycle", int'(err_pulse), 1);
        if (exp_errs < 15) exp_errs++;
        chk("R11 err_cnt after timeout", int'(err_cnt), exp_errs);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        rst_n   = 1'b0;
        in_vld  = 1'b0;
        in_byte = 8'h00;
        rd_addr = '0;
        repeat (4) tick();
        chk("R1 rec_rdy in reset", int'(rec_rdy), 0);
        chk("R1 err_pulse in reset", int'(err_pulse), 0);
        chk("R1 err_cnt in reset", int'(err_cnt), 0);
        rst_n = 1'b1;
        tick();

        // R2: junk, including an end marker, while hunting.
        seen = 0;
        send(8'h33); seen += int'(rec_rdy) + int'(err_pulse);
        send(EOF);   seen += int'(rec_rdy) + int'(err_pulse);
        send(8'h44); seen += int'(rec_rdy) + int'(err_pulse);
        chk("R2 hunt ignores bytes", seen, 0);

        // R1/R3/R4/R5/R12: table of frames, first at address 0.
        for (int v = 0; v < 6; v++) begin
            repeat (int'(VEC[v][24:17])) tick();
            good_frame("R3 R4 R5 R12 table", int'(VEC[v][16:8]), VEC[v][7:0]);
        end

        // R6: a byte after 63 idle cycles keeps the frame alive.
        send(SOF);
        send(dat(8'h60, 0));
        repeat (63) tick();
        chk("R6 63 idle cycles tolerated", int'(err_pulse), 0);
        send(dat(8'h60, 1));
        send(EOF);
        expect_commit("R6 frame after 63 idle", 2);
        readback("R6", 2, 8'h60);
        exp_start = exp_start + ADDR_W'(2);

        // R6/R8/R11: timeout abort with a partial record.
        send(SOF);
        send(dat(8'h70, 0));
        repeat (63) tick();
        chk("R6 no abort at 63", int'(err_pulse), 0);
        tick();
        chk("R6 abort at 64", int'(err_pulse), 1);
        chk("R8 no rdy on abort", int'(rec_rdy), 0);
        exp_errs++;
        chk("R11 err_cnt first abort", int'(err_cnt), exp_errs);
        tick();
        chk("R8 err single cycle", int'(err_pulse), 0);

        // R9: junk after abort, then a frame at the restored address.
        send(8'h11);
        chk("R9 junk after abort ignored", int'(rec_rdy) + int'(err_pulse), 0);
        good_frame("R8 R9 restored start", 2, 8'h90);

        // R7: one byte beyond the frame limit aborts.
        send(SOF);
        for (int i = 0; i < 256; i++)
            send(dat(8'h00, i));
        chk("R7 256 bytes no abort", int'(err_pulse), 0);
        send(8'h12);
        chk("R7 abort on 257th byte", int'(err_pulse), 1);
        exp_errs++;
        chk("R11 err_cnt after overflow", int'(err_cnt), exp_errs);
        tick();
        good_frame("R7 R8 exact max frame", 256, 8'h03);

        // R10: a start marker mid-frame restarts the record.
        send(SOF);
        send(8'h21);
        send(8'h22);
        send(SOF);
        chk("R10 restart no error", int'(err_pulse), 0);
        send(dat(8'hC0, 0));
        send(EOF);
        expect_commit("R10 restart", 1);
        readback("R10", 1, 8'hC0);
        exp_start = exp_start + ADDR_W'(1);

        // R11: drive aborts until the counter saturates.
        while (exp_errs < 15)
            idle_abort();
        chk("R11 err_cnt at max", int'(err_cnt), 15);
        idle_abort();
        chk("R11 err_cnt saturated", int'(err_cnt), 15);

        // R9: still receiving after many aborts.
        good_frame("R9 resume after aborts", 4, 8'hD0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule